// File: doc/BRIEF.md
# Sixteen-Bit Lookahead Arithmetic/Logic Unit

This block is a purely combinational arithmetic/logic unit for a datapath. It takes two 16-bit operands and a 3-bit operation code. It returns a 16-bit result, a carry-out and a signed overflow flag. Sums and differences come from a single adder. Each bit of the adder feeds its generate and propagate terms into one of four 4-bit lookahead groups. A second-level lookahead unit turns the group terms into the carries entering groups 1 to 3. A pairwise reduction of the group terms gives the final carry-out.

Subtraction uses the same adder. The second operand is inverted bit by bit and the carry into bit 0 is forced to one. The signed overflow flag is derived from the operand signs and the result sign, with a separate rule for addition and for subtraction. Overflow is only reported as a flag and never stops the operation. The unit also offers four bitwise operations. Undefined operation codes give a zero output.

Top module: `lk_alu`

## Requirements
- R1: With op_sel = 3'b000 (add), result equals (opa + opb) mod 2^16, and carry_out equals bit 16 of the unsigned sum.
- R2: With op_sel = 3'b001 (subtract), result equals (opa - opb) mod 2^16, and carry_out is 1 exactly when opa >= opb as unsigned numbers (no borrow).
- R3: On add, ovf is 1 exactly when both operands have bit 15 clear and the result has bit 15 set, or when both operands have bit 15 set and the result has bit 15 clear.
- R4: On subtract, ovf is 1 exactly when opa[15]=0, opb[15]=1 and result[15]=1, or when opa[15]=1, opb[15]=0 and result[15]=0. Operands with equal sign bits never raise ovf on subtract.
- R5: op_sel 3'b010 gives opa AND opb, 3'b011 gives opa OR opb, 3'b100 gives opa XOR opb and 3'b101 gives NOT(opa OR opb).
- R6: For the four bitwise codes of R5, carry_out and ovf are 0.
- R7: op_sel 3'b110 and 3'b111 give result 0, carry_out 0 and ovf 0.
- R8: A carry produced in any bit reaches every later 4-bit group and the carry-out. For example, 0xFFFF + 0x0001 gives result 0x0000 with carry_out 1, and 0x00FF + 0x0001 gives 0x0100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand (subtrahend on subtract) |
| op_sel | input | 3 | Operation code |
| result | output | 16 | Operation result |
| carry_out | output | 1 | Carry out of bit 15 on add/subtract, else 0 |
| ovf | output | 1 | Signed overflow on add/subtract, else 0 |

## Verification
Carry-out and signed overflow can be raised together by one operation. The bench provokes this with 0x8000 + 0x8000, where both flags are set and the result is zero. It also uses 0x7FFF + 0x0001, which overflows with no carry, and 0x8000 - 0x0001, which overflows while carry_out reports no borrow. Each flag is compared on its own against a reference computed with wide integer arithmetic, so a design that merged or swapped the two flags fails on at least one of these patterns.

// File: rtl/lk_alu_pkg.sv
package lk_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_AND = 3'b010,
    OP_OR  = 3'b011,
    OP_XOR = 3'b100,
    OP_NOR = 3'b101
  } alu_op_e;

  function automatic logic is_arith(input logic [2:0] code);
    return (code == OP_ADD) || (code == OP_SUB);
  endfunction

endpackage

// File: rtl/lk_cla_group.sv
// One lookahead group: per-bit generate/propagate, carries inside the
// group from flattened lookahead terms, and group generate/propagate.
module lk_cla_group #(
  parameter int GW = 4
) (
  input  logic [GW-1:0] a,
  input  logic [GW-1:0] b,
  input  logic          cin,
  output logic [GW-1:0] sum,
  output logic          grp_g,
  output logic          grp_p
);

  logic [GW-1:0] bit_g;
  logic [GW-1:0] bit_p;
  logic [GW-1:0] bit_x;
  logic [GW-1:0] carry;

  assign bit_g = a & b;
  assign bit_p = a | b;
  assign bit_x = a ^ b;

  // carry[k] = OR over j<k of (g[j] AND p[j+1..k-1]) OR (cin AND p[0..k-1])
  always_comb begin
    logic acc;
    logic term;
    carry    = '0;
    carry[0] = cin;
    for (int k = 1; k < GW; k++) begin
      acc = 1'b0;
      for (int j = 0; j < k; j++) begin
        term = bit_g[j];
        for (int m = j + 1; m < k; m++) term = term & bit_p[m];
        acc = acc | term;
      end
      term = cin;
      for (int m = 0; m < k; m++) term = term & bit_p[m];
      carry[k] = acc | term;
    end
  end

  always_comb begin
    logic term;
    grp_g = 1'b0;
    for (int j = 0; j < GW; j++) begin
      term = bit_g[j];
      for (int m = j + 1; m < GW; m++) term = term & bit_p[m];
      grp_g = grp_g | term;
    end
  end

  assign grp_p = &bit_p;
  assign sum   = bit_x ^ carry;

endmodule

// File: rtl/lk_cla_tree.sv
// Second-level lookahead: group carries from group G/P, plus a pairwise
// G/P reduction whose root yields the final carry-out.
module lk_cla_tree #(
  parameter int NG = 4
) (
  input  logic [NG-1:0] gg,
  input  logic [NG-1:0] gp,
  input  logic          cin,
  output logic [NG-1:0] gcin,
  output logic          cout
);

  localparam int LV = (NG > 1) ? $clog2(NG) : 1;

  logic [LV:0][NG-1:0] lg;
  logic [LV:0][NG-1:0] lp;

  always_comb begin
    logic acc;
    logic term;
    gcin    = '0;
    gcin[0] = cin;
    for (int k = 1; k < NG; k++) begin
      acc = 1'b0;
      for (int j = 0; j < k; j++) begin
        term = gg[j];
        for (int m = j + 1; m < k; m++) term = term & gp[m];
        acc = acc | term;
      end
      term = cin;
      for (int m = 0; m < k; m++) term = term & gp[m];
      gcin[k] = acc | term;
    end
  end

  assign lg[0] = gg;
  assign lp[0] = gp;

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    for (genvar i = 0; i < NG; i++) begin : g_node
      if (i < (NG >> (l + 1))) begin : g_pair
        assign lg[l+1][i] = lg[l][2*i+1] | (lp[l][2*i+1] & lg[l][2*i]);
        assign lp[l+1][i] = lp[l][2*i+1] & lp[l][2*i];
      end else begin : g_idle
        assign lg[l+1][i] = 1'b0;
        assign lp[l+1][i] = 1'b0;
      end
    end
  end

  assign cout = lg[LV][0] | (lp[LV][0] & cin);

endmodule

// File: rtl/lk_logic_unit.sv
module lk_logic_unit
  import lk_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   op,
  output logic [W-1:0] y
);

  always_comb begin
    case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_NOR:  y = ~(a | b);
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/lk_alu.sv
module lk_alu
  import lk_alu_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int GROUP_W = 4
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [2:0]       op_sel,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             ovf
);

  localparam int NG  = WIDTH / GROUP_W;
  localparam int MSB = WIDTH - 1;

  logic             do_sub;
  logic             do_arith;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] sum;
  logic [NG-1:0]    gg;
  logic [NG-1:0]    gp;
  logic [NG-1:0]    gcin;
  logic             add_cout;
  logic [WIDTH-1:0] logic_y;
  logic             ovf_add;
  logic             ovf_sub;

  assign do_sub   = (op_sel == OP_SUB);
  assign do_arith = is_arith(op_sel);
  assign b_eff    = opb ^ {WIDTH{do_sub}};

  for (genvar i = 0; i < NG; i++) begin : g_grp
    lk_cla_group #(.GW(GROUP_W)) u_grp (
      .a     (opa[i*GROUP_W +: GROUP_W]),
      .b     (b_eff[i*GROUP_W +: GROUP_W]),
      .cin   (gcin[i]),
      .sum   (sum[i*GROUP_W +: GROUP_W]),
      .grp_g (gg[i]),
      .grp_p (gp[i])
    );
  end

  lk_cla_tree #(.NG(NG)) u_tree (
    .gg   (gg),
    .gp   (gp),
    .cin  (do_sub),
    .gcin (gcin),
    .cout (add_cout)
  );

  lk_logic_unit #(.W(WIDTH)) u_logic (
    .a  (opa),
    .b  (opb),
    .op (op_sel),
    .y  (logic_y)
  );

  assign ovf_add = (~opa[MSB] & ~opb[MSB] &  sum[MSB]) |
                   ( opa[MSB] &  opb[MSB] & ~sum[MSB]);
  assign ovf_sub = (~opa[MSB] &  opb[MSB] &  sum[MSB]) |
                   ( opa[MSB] & ~opb[MSB] & ~sum[MSB]);

  assign result    = do_arith ? sum : logic_y;
  assign carry_out = do_arith & add_cout;
  assign ovf       = do_arith & (do_sub ? ovf_sub : ovf_add);

endmodule

// File: rtl/lk_alu_chk.sv
module lk_alu_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic [2:0]       op_sel,
  input logic [WIDTH-1:0] result,
  input logic             carry_out,
  input logic             ovf
);

  localparam int MSB = WIDTH - 1;

  always_comb begin
    if (!$isunknown({opa, opb, op_sel, result, carry_out, ovf})) begin
      if (op_sel == 3'b000 && opb == '0)
        assert_add_zero_R1: assert (result == opa && !carry_out);
      if (op_sel == 3'b001 && opa == opb)
        assert_sub_self_R2: assert (result == '0 && carry_out);
      if (op_sel == 3'b000 && ovf)
        assert_add_ovf_sign_R3: assert (opa[MSB] == opb[MSB] && result[MSB] != opa[MSB]);
      if (op_sel == 3'b001 && opa[MSB] == opb[MSB])
        assert_no_overflow_R4: assert (!ovf);
      if (op_sel == 3'b010)
        assert_and_subset_R5: assert ((result & ~opa) == '0 && (result & ~opb) == '0);
      if (op_sel >= 3'b010 && op_sel <= 3'b101)
        assert_logic_flags_R6: assert (!carry_out && !ovf);
      if (op_sel >= 3'b110)
        assert_idle_zero_R7: assert (result == '0 && !carry_out && !ovf);
    end
  end

endmodule

bind lk_alu lk_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .opa       (opa),
  .opb       (opb),
  .op_sel    (op_sel),
  .result    (result),
  .carry_out (carry_out),
  .ovf       (ovf)
);

// File: tb/sim_lk_alu.sv
module sim_lk_alu;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [15:0] opa;
  logic [15:0] opb;
  logic [2:0]  op_sel;
  logic [15:0] result;
  logic        carry_out;
  logic        ovf;

  int n_run;
  int n_fail;
  bit done;

  lk_alu u0 (
    .opa       (opa),
    .opb       (opb),
    .op_sel    (op_sel),
    .result    (result),
    .carry_out (carry_out),
    .ovf       (ovf)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic model(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b,
                       output logic [15:0] er, output logic ec, output logic eo);
    logic [16:0] wide;
    int          s;
    er = '0; ec = 1'b0; eo = 1'b0;
    case (op)
      3'b000: begin
        wide = {1'b0, a} + {1'b0, b};
        er = wide[15:0]; ec = wide[16];
        s = int'($signed(a)) + int'($signed(b));
        eo = (s > 32767) || (s < -32768);
      end
      3'b001: begin
        er = a - b; ec = (a >= b);
        s = int'($signed(a)) - int'($signed(b));
        eo = (s > 32767) || (s < -32768);
      end
      3'b010: er = a & b;
      3'b011: er = a | b;
      3'b100: er = a ^ b;
      3'b101: er = ~(a | b);
      default: er = '0;
    endcase
  endtask

  task automatic apply(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b,
                       input string rq);
    logic [15:0] er;
    logic        ec;
    logic        eo;
    @(posedge clk);
    op_sel = op; opa = a; opb = b;
    model(op, a, b, er, ec, eo);
    @(negedge clk);
    n_run++;
    if (result !== er || carry_out !== ec || ovf !== eo) begin
      n_fail++;
      $display("FAIL %s op=%b a=%h b=%h got r=%h c=%b v=%b exp r=%h c=%b v=%b",
               rq, op, a, b, result, carry_out, ovf, er, ec, eo);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; opa = '0; opb = '0; op_sel = 3'b000;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_run++;
    if (result !== 16'h0 || carry_out !== 1'b0 || ovf !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset state got r=%h c=%b v=%b exp r=0000 c=0 v=0",
               result, carry_out, ovf);
    end
  endtask

  task automatic t_corners;
    apply(3'b000, 16'h7FFF, 16'h0001, "R3");
    apply(3'b001, 16'h8000, 16'h0001, "R4");
    apply(3'b000, 16'h8000, 16'h8000, "R3");
    apply(3'b001, 16'h7FFF, 16'hFFFF, "R4");
    apply(3'b001, 16'h1234, 16'h1234, "R2");
    apply(3'b001, 16'h0000, 16'h0001, "R2");
    apply(3'b001, 16'h8000, 16'h8000, "R4");
    apply(3'b000, 16'hFFFF, 16'hFFFF, "R1");
  endtask

  task automatic t_carry_chain;
    apply(3'b000, 16'hFFFF, 16'h0001, "R8");
    apply(3'b000, 16'h00FF, 16'h0001, "R8");
    apply(3'b000, 16'h000F, 16'h0001, "R8");
    apply(3'b000, 16'h0FFF, 16'h0001, "R8");
    apply(3'b001, 16'h1000, 16'h0001, "R8");
  endtask

  task automatic t_logic;
    apply(3'b010, 16'hF0F0, 16'hFF00, "R5");
    apply(3'b011, 16'hF0F0, 16'h0F00, "R5");
    apply(3'b100, 16'hAAAA, 16'hFFFF, "R5");
    apply(3'b101, 16'h0000, 16'h0000, "R5");
    apply(3'b010, 16'hFFFF, 16'hFFFF, "R6");
    apply(3'b101, 16'h8000, 16'h8000, "R6");
  endtask

  task automatic t_idle_codes;
    apply(3'b110, 16'hFFFF, 16'hFFFF, "R7");
    apply(3'b111, 16'h8000, 16'h8000, "R7");
  endtask

  task automatic t_random;
    for (int i = 0; i < 1600; i++) begin
      logic [2:0]  op;
      logic [15:0] a;
      logic [15:0] b;
      op = 3'(i % 8);
      a  = 16'($urandom);
      b  = 16'($urandom);
      case (op)
        3'b000: apply(op, a, b, "R1");
        3'b001: apply(op, a, b, "R2");
        3'b110, 3'b111: apply(op, a, b, "R7");
        default: apply(op, a, b, "R5");
      endcase
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    void'($urandom(32'h5EED));
    t_reset;
    t_corners;
    t_carry_chain;
    t_logic;
    t_idle_codes;
    t_random;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule